// File: doc/BRIEF.md
# Instruction Prefetch Queue with Store Snooping

This block is a small byte-wide queue placed between the memory fetch port and the instruction decoder. It keeps fetching sequential instruction bytes ahead of the point of execution, up to six bytes by default, and hands them to the decoder one byte per accepted take. The memory side uses a simple request/response port, with one request in flight at most.

Because the core may write into its own instruction stream, every data store address is presented to a snoop input. Only the low eight bits of the store address are compared with the low eight bits of every byte still held, and with the address of any fetch in flight. On a match the whole queue is discarded and fetching restarts at the oldest byte the decoder has not yet taken. The new bytes then come from memory. Aliased addresses cause needless flushes. These cost only cycles, and the decoder never sees a stale byte.

A taken branch enters through the redirect input. It empties the queue and restarts both the fetch pointer and the decoder address at the target. A response to a request that was issued before a flush or redirect is marked stale and dropped when it arrives.

Top module: `ipq_snoop_top`

## Requirements
- R1: After reset the queue is empty (`dec_valid` low), `fetch_req` is high and `fetch_addr` equals the parameter RESET_ADDR.
- R2: The queue holds at most DEPTH bytes (default 6). No request is issued while it is full, and only one request is outstanding at a time.
- R3: Bytes reach the decoder in address order with no gaps. `dec_addr` goes up by one after each take, and `dec_byte` is the memory content at `dec_addr`.
- R4: A store whose address bits [7:0] equal bits [7:0] of the address of any held byte empties the queue in the next cycle. The decoder then only sees bytes that were read after the store.
- R5: Address bits above bit 7 take no part in the compare. A store that differs from a held byte only in those bits also empties the queue.
- R6: A store whose bits [7:0] match no held byte and no fetch in flight leaves the queue, `dec_addr` and `fetch_addr` unchanged. This includes a store to a byte that has already been taken.
- R7: After a snoop flush, `fetch_addr` equals the address of the oldest byte not yet taken, not the fetch-ahead address.
- R8: A response to a request issued before a flush or redirect is dropped. A store whose bits [7:0] match the address of a request in flight also forces a flush and refetch.
- R9: A redirect empties the queue and sets `fetch_addr` and `dec_addr` to `redirect_addr` in the next cycle. If it coincides with a snoop match, the redirect target wins.
- R10: A store that matches the byte being taken in the same cycle still flushes the rest of the queue, and refetching starts at the following address.
- R11: A take and a fill in the same cycle both take effect, so the byte count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Fetch request valid |
| fetch_addr | output | ADDR_W | Byte address of the next fetch (the fetch pointer) |
| fetch_ready | input | 1 | Memory accepts the request this cycle |
| rsp_valid | input | 1 | Response byte valid for the request in flight |
| rsp_data | input | 8 | Response byte |
| dec_valid | output | 1 | A byte is available to the decoder |
| dec_byte | output | 8 | Oldest byte not yet taken |
| dec_addr | output | ADDR_W | Address of the oldest byte not yet taken |
| dec_take | input | 1 | Decoder takes the byte this cycle |
| redirect | input | 1 | Taken branch; restart at `redirect_addr` |
| redirect_addr | input | ADDR_W | Branch target |
| store_valid | input | 1 | A data store happens this cycle |
| store_addr | input | ADDR_W | Store byte address |

## Verification
The assertions rely on the memory model sending exactly one response per accepted request, at least one cycle after acceptance, and never sending a response when no request is in flight. They also rely on a store becoming visible to any fetch accepted in a later cycle. The bench memory keeps to this: it queues the one accepted address, answers it after a fixed latency with the byte stored there at that moment, and applies each store at the same edge where the block sees it. Redirects and stores are driven freely, and they also land on the cycles in which a request is being accepted or answered.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  // compare width is fixed by the snoop scheme, not by the address width
  localparam int SNOOP_W = 8;

  typedef logic [7:0]         byte_t;
  typedef logic [SNOOP_W-1:0] tag_t;

  typedef struct packed {
    byte_t data;
    tag_t  tag;
  } slot_t;

  function automatic logic tag_eq(tag_t a, tag_t b);
    return a == b;
  endfunction
endpackage

// File: rtl/ipq_entries.sv
module ipq_entries
  import ipq_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  byte_t                        push_data,
  input  tag_t                         push_tag,
  input  logic                         pop,
  input  logic                         clear,
  input  tag_t                         snoop_tag,
  output slot_t                        head_slot,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         q_hit
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  slot_t            slots [DEPTH];
  logic [PW-1:0]    head, tail;
  logic [DEPTH-1:0] live, match;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // slot idx holds a byte when its ring distance from head is below cnt
  function automatic logic slot_live(int idx, logic [PW-1:0] hd, logic [CW-1:0] c);
    int d;
    d = idx - int'(hd);
    if (d < 0) d = d + DEPTH;
    return d < int'(c);
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign live[gi]  = slot_live(gi, head, cnt);
      assign match[gi] = live[gi] && tag_eq(slots[gi].tag, snoop_tag);
    end
  endgenerate

  assign q_hit     = |match;
  assign head_slot = slots[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (clear) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) tail <= ptr_inc(tail);
      if (pop)  head <= ptr_inc(head);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) slots[tail] <= '{data: push_data, tag: push_tag};
  end

  // R2: a fill from the fetch side never lands on a full queue
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)));
endmodule

// File: rtl/ipq_fetch.sv
module ipq_fetch
  import ipq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              space_ok,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_addr,
  input  tag_t              snoop_tag,
  input  logic              fetch_ready,
  input  logic              rsp_valid,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fill,
  output tag_t              fill_tag,
  output logic              pend_hit,
  output logic              pend_stale
);
  logic [ADDR_W-1:0] fptr, inflight_addr;
  logic              outstanding, stale;
  logic              accept_evt;

  function automatic tag_t low_tag(logic [ADDR_W-1:0] a);
    return a[SNOOP_W-1:0];
  endfunction

  assign fetch_req  = !outstanding && space_ok;
  assign fetch_addr = fptr;
  assign accept_evt = fetch_req && fetch_ready;
  assign fill       = rsp_valid && outstanding && !stale && !restart;
  assign fill_tag   = low_tag(inflight_addr);
  assign pend_stale = stale;
  // a store may overtake a fetch in flight or one leaving this cycle
  assign pend_hit   = (outstanding && !stale && tag_eq(low_tag(inflight_addr), snoop_tag))
                   || (accept_evt && tag_eq(low_tag(fptr), snoop_tag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fptr          <= ADDR_W'(RESET_ADDR);
      inflight_addr <= '0;
      outstanding   <= 1'b0;
      stale         <= 1'b0;
    end else begin
      if (restart)         fptr <= restart_addr;
      else if (accept_evt) fptr <= fptr + 1'b1;

      if (accept_evt) begin
        outstanding   <= 1'b1;
        stale         <= restart;
        inflight_addr <= fptr;
      end else if (rsp_valid) begin
        outstanding <= 1'b0;
        stale       <= 1'b0;
      end else if (restart && outstanding) begin
        stale <= 1'b1;
      end
    end
  end

  // R2: only one request in flight, so no request while one is pending
  p_single_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !restart) |=> !fetch_req);
endmodule

// File: rtl/ipq_snoop_top.sv
module ipq_snoop_top
  import ipq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DEPTH      = 6,
  parameter int unsigned RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ready,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              dec_valid,
  output logic [7:0]        dec_byte,
  output logic [ADDR_W-1:0] dec_addr,
  input  logic              dec_take,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              store_valid,
  input  logic [ADDR_W-1:0] store_addr
);
  localparam int CW = $clog2(DEPTH+1);

  logic [ADDR_W-1:0] head_addr, restart_addr, head_next;
  logic [CW-1:0]     cnt;
  slot_t             head_slot;
  tag_t              snoop_tag, fill_tag;
  logic              q_hit, pend_hit, pend_stale;
  logic              fill_evt, pop_evt, snoop_hit, flush_evt, restart_evt, space_ok;

  assign snoop_tag    = store_addr[SNOOP_W-1:0];
  assign pop_evt      = dec_take && dec_valid;
  assign snoop_hit    = store_valid && (q_hit || pend_hit);
  assign flush_evt    = snoop_hit && !redirect;
  assign restart_evt  = redirect || snoop_hit;
  assign head_next    = head_addr + ADDR_W'(pop_evt);
  assign restart_addr = redirect ? redirect_addr : head_next;
  assign space_ok     = cnt < CW'(DEPTH);

  assign dec_valid = (cnt != '0);
  assign dec_byte  = head_slot.data;
  assign dec_addr  = head_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)        head_addr <= ADDR_W'(RESET_ADDR);
    else if (redirect) head_addr <= redirect_addr;
    else               head_addr <= head_next;
  end

  ipq_fetch #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .space_ok    (space_ok),
    .restart     (restart_evt),
    .restart_addr(restart_addr),
    .snoop_tag   (snoop_tag),
    .fetch_ready (fetch_ready),
    .rsp_valid   (rsp_valid),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .fill        (fill_evt),
    .fill_tag    (fill_tag),
    .pend_hit    (pend_hit),
    .pend_stale  (pend_stale)
  );

  ipq_entries #(.DEPTH(DEPTH)) u_entries (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (fill_evt),
    .push_data(rsp_data),
    .push_tag (fill_tag),
    .pop      (pop_evt),
    .clear    (restart_evt),
    .snoop_tag(snoop_tag),
    .head_slot(head_slot),
    .cnt      (cnt),
    .q_hit    (q_hit)
  );

  // R4: a snoop match leaves nothing for the decoder in the next cycle
  p_flush_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit |=> !dec_valid);

  // R7: refetch starts where the decoder stands
  p_refetch_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (fetch_addr == dec_addr));

  // R9: redirect target wins over any snoop match
  p_redirect_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!dec_valid && fetch_addr == $past(redirect_addr)
                  && dec_addr == $past(redirect_addr)));

  // R8: while a stale response is pending, the queue stays empty
  p_stale_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pend_stale) |=> !dec_valid);

  // R3: each take moves the decoder address by one
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !redirect) |=> (dec_addr == $past(dec_addr) + 1'b1));
endmodule

// File: tb/tb_ipq_snoop_top.sv
module tb_ipq_snoop_top;
  localparam int AW  = 10;
  localparam int DEP = 6;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_req, fetch_ready, rsp_valid;
  logic [AW-1:0] fetch_addr, dec_addr, redirect_addr, store_addr;
  logic [7:0]    rsp_data, dec_byte;
  logic          dec_valid, dec_take, redirect, store_valid;

  always #4 clk = ~clk;  // 125 MHz

  ipq_snoop_top #(.ADDR_W(AW), .DEPTH(DEP), .RESET_ADDR(0)) dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dec_valid(dec_valid), .dec_byte(dec_byte), .dec_addr(dec_addr), .dec_take(dec_take),
    .redirect(redirect), .redirect_addr(redirect_addr),
    .store_valid(store_valid), .store_addr(store_addr)
  );

  logic [7:0]    mem [1024];
  logic [AW-1:0] pc, pend_addr;
  logic          pend_valid, ready_en;
  logic [7:0]    st_data;
  int            pend_cnt, accepts, consumed;
  int            checks = 0, failures = 0;
  bit            done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    logic          acc, took;
    logic [AW-1:0] acc_a;
    rsp_valid   = pend_valid && pend_cnt == 0;
    rsp_data    = mem[pend_addr];
    fetch_ready = ready_en;
    #1;
    acc   = fetch_req && fetch_ready;
    acc_a = fetch_addr;
    took  = dec_valid && dec_take;
    if (dec_valid) begin
      chk(dec_addr == pc, "R3", "dec_addr", int'(dec_addr), int'(pc));
      chk(dec_byte == mem[pc], "R4", "dec_byte", int'(dec_byte), int'(mem[pc]));
    end
    @(posedge clk);
    if (rsp_valid) pend_valid = 1'b0;
    if (acc) begin
      pend_valid = 1'b1; pend_addr = acc_a; pend_cnt = LAT - 1; accepts++;
    end else if (pend_valid && pend_cnt > 0) pend_cnt--;
    if (redirect) pc = redirect_addr;
    else if (took) pc = pc + 1'b1;
    if (took) consumed++;
    if (store_valid) mem[store_addr] = st_data;
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic go_to(logic [AW-1:0] a);
    redirect = 1'b1; redirect_addr = a;
    step();
    redirect = 1'b0;
    accepts = 0;
  endtask

  task automatic fill_full(logic [AW-1:0] a);
    dec_take = 1'b0; ready_en = 1'b1;
    go_to(a);
    steps(30);
  endtask

  task automatic store1(logic [AW-1:0] a, logic [7:0] d);
    store_valid = 1'b1; store_addr = a; st_data = d;
    step();
    store_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    rst_n = 1'b0; fetch_ready = 0; rsp_valid = 0; rsp_data = 0;
    dec_take = 0; redirect = 0; redirect_addr = 0; store_valid = 0; store_addr = 0;
    st_data = 0; pc = 0; pend_addr = 0; pend_valid = 0; pend_cnt = 0;
    ready_en = 0; accepts = 0; consumed = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dec_valid == 1'b0, "R1", "dec_valid", int'(dec_valid), 0);
    chk(fetch_req == 1'b1, "R1", "fetch_req", int'(fetch_req), 1);
    chk(fetch_addr == '0, "R1", "fetch_addr", int'(fetch_addr), 0);

    // R2 capacity
    fill_full(10'h020);
    chk(fetch_req == 1'b0, "R2", "fetch_req when full", int'(fetch_req), 0);
    chk(accepts == DEP, "R2", "bytes fetched", accepts, DEP);

    // R4 R5 R6 R7 sweep: bytes consumed k, store offset d, alias a
    for (int k = 0; k < DEP; k++)
      for (int d = 0; d < 9; d++)
        for (int a = 0; a < 2; a++) begin
          logic [AW-1:0] base;
          bit hit;
          base = AW'(k * 171 + 1020);
          fill_full(base);
          ready_en = 1'b0; dec_take = 1'b1;
          steps(k);
          dec_take = 1'b0;
          hit = (d >= k) && (d < DEP);
          store1(base + AW'(d) + AW'(a * 256), 8'(k * 16 + d));
          chk(dec_valid == !hit, a ? "R5" : (hit ? "R4" : "R6"), "dec_valid after store",
              int'(dec_valid), int'(!hit));
          chk(fetch_addr == (hit ? base + AW'(k) : base + AW'(DEP)), hit ? "R7" : "R6",
              "fetch_addr after store", int'(fetch_addr),
              int'(hit ? base + AW'(k) : base + AW'(DEP)));
          chk(dec_addr == base + AW'(k), "R6", "dec_addr after store",
              int'(dec_addr), int'(base + AW'(k)));
        end

    // R9 redirect and snoop match together
    fill_full(10'h150);
    ready_en = 1'b0;
    redirect = 1'b1; redirect_addr = 10'h2A0;
    store1(10'h152, 8'h11);
    redirect = 1'b0;
    chk(fetch_addr == 10'h2A0, "R9", "fetch_addr", int'(fetch_addr), 'h2A0);
    chk(dec_addr == 10'h2A0, "R9", "dec_addr", int'(dec_addr), 'h2A0);
    chk(dec_valid == 1'b0, "R9", "dec_valid", int'(dec_valid), 0);

    // R10 take and matching store on the head byte together
    fill_full(10'h180);
    ready_en = 1'b0; dec_take = 1'b1;
    store1(10'h180, 8'h22);
    dec_take = 1'b0;
    chk(dec_valid == 1'b0, "R10", "dec_valid", int'(dec_valid), 0);
    chk(fetch_addr == 10'h181, "R10", "fetch_addr", int'(fetch_addr), 'h181);

    // R8 stale response after redirect
    ready_en = 1'b1; dec_take = 1'b0;
    go_to(10'h100);
    for (int i = 0; i < 10 && !(pend_valid && pend_addr == 10'h100); i++) step();
    go_to(10'h205);
    steps(30);
    chk(dec_valid && dec_addr == 10'h205, "R8", "head after redirect", int'(dec_addr), 'h205);
    chk(dec_byte == mem[10'h205], "R8", "byte after stale drop", int'(dec_byte), int'(mem[10'h205]));

    // R8 store to an address in flight
    go_to(10'h0C0);
    for (int i = 0; i < 10 && !(pend_valid && pend_addr == 10'h0C0); i++) step();
    store1(10'h0C0, 8'hA5);
    steps(30);
    chk(dec_valid && dec_addr == 10'h0C0, "R8", "head after in-flight store", int'(dec_addr), 'h0C0);
    chk(dec_byte == 8'hA5, "R8", "refetched byte", int'(dec_byte), 'hA5);

    // R11 take and fill in one cycle
    fill_full(10'h300);
    ready_en = 1'b0; dec_take = 1'b1;
    step();
    dec_take = 1'b0; ready_en = 1'b1;
    for (int i = 0; i < 10 && !(pend_valid && pend_cnt == 0); i++) step();
    dec_take = 1'b1;
    step();
    dec_take = 1'b0;
    chk(fetch_req == 1'b1, "R11", "fetch_req after take+fill", int'(fetch_req), 1);
    steps(20);
    chk(fetch_req == 1'b0, "R11", "fetch_req refilled", int'(fetch_req), 0);
    chk(dec_addr == 10'h302, "R11", "dec_addr", int'(dec_addr), 'h302);
    ready_en = 1'b0; dec_take = 1'b1;
    consumed = 0;
    steps(9);
    dec_take = 1'b0;
    chk(consumed == DEP, "R11", "bytes drained", consumed, DEP);

    // mixed traffic: stores near pc, aliases, redirects, stalls
    consumed = 0;
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom % 100);
      dec_take = ($urandom % 10) < 6;
      ready_en = ($urandom % 10) < 7;
      redirect = (r < 2);
      redirect_addr = AW'($urandom);
      store_valid = (r >= 2 && r < 14);
      store_addr = pc + AW'(int'($urandom % 12) - 2) + ((($urandom % 4) == 0) ? AW'(256) : AW'(0));
      st_data = 8'($urandom);
      step();
    end
    redirect = 0; store_valid = 0; dec_take = 0;
    chk(consumed > 500, "R3", "forward progress", consumed, 500);
    finish_run();
  end
endmodule